// File: doc/BRIEF.md
# Thermal Shutdown Controller with Escalating Cooldown

This block guards a board against overheating. It compares two signed temperature readings in degrees C against fixed limits. One reading comes from a sensor on the board and the other from a remote sensor at the CPU junction. When protection is enabled and either reading is above its limit, the block drops its power-enable output. It holds power off for a cooldown period counted in ticks of a 1 Hz strobe, and then restores power.

Repeated trips lengthen the cooldown. The first cooldown is short. Each completed cooldown extends the next one by a fixed step, up to a ceiling. The length falls back to the minimum after the board runs for a full stability window without a trip. Each trip also raises a one-cycle pulse with a cause code, which the reset-cause logic next to this block stores.

Top module: `thermal_guard`

## Requirements
- R1: After reset, power is enabled, the trip pulse is low and the reported cooldown length is 5 s.
- R2: While protection is enabled and power is on, a board reading strictly greater than 85 causes a trip. A reading of exactly 85 does not.
- R3: While protection is enabled and power is on, a remote reading strictly greater than 100 causes a trip. A reading of exactly 100 does not.
- R4: The trip cause code is 4 for the board sensor and 5 for the remote sensor. When both sensors exceed their limits in the same cycle, the code is 4.
- R5: While the enable input is 0, no reading causes a trip and power stays on.
- R6: A trip drops power-enable in the cycle its pulse is high. Power then stays off for exactly as many 1 Hz ticks as the cooldown length reported when the trip happened.
- R7: When power is restored, the cooldown length grows by 30 s. It never exceeds 300 s, so the sequence is 5, 35, 65, … 275, 300, 300.
- R8: Once power is on, whether after reset or after a cooldown, 300 ticks without a trip return the cooldown length to 5 s. After 299 ticks the length is unchanged.
- R9: While power is off, temperature readings are ignored. They raise no pulse and do not restart or extend the cooldown.
- R10: The trip pulse is high for exactly one clock cycle per trip.
- R11: Temperature readings are two's-complement signed, so readings below zero never cause a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| prot_en | input | 1 | Protection enable, taken from bit 0 of the configuration register |
| local_temp | input | TEMP_W | Board temperature, signed, in degrees C |
| remote_temp | input | TEMP_W | CPU junction temperature, signed, in degrees C |
| pwr_en | output | 1 | Primary power enable, 1 = on |
| trip_pulse | output | 1 | One-cycle pulse when a trip occurs |
| trip_cause | output | 4 | Cause code, valid with the pulse: 4 = board, 5 = remote |
| cooldown_secs | output | CNT_W | Current cooldown length in seconds |

## Verification
The bench drives each reading exactly at its limit and one degree above it, and it also drives negative readings. A design with an off-by-one limit or an unsigned compare would trip at the limit or on a cold reading. It counts the ticks of every cooldown against the length reported before the trip. A timer that loads the length after it has grown, or that is off by one tick, would restore power one tick early, one tick late, or after the wrong cooldown. It holds both sensors hot for a whole cooldown and drives them hot together. A design that re-arms while power is off would emit extra pulses, and one with the wrong priority would report cause 5. It walks the length up to the ceiling and past it, and then stops one tick short of the stability window and at the window. This exposes a missing clamp and a window that is one tick off.

// File: rtl/tg_pkg.sv
// Package: shared types and constants for the thermal guard.
// Assumes: cause codes are consumed by a neighbouring reset-cause register.
package tg_pkg;
    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_LOCAL  = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_REMOTE = 4'd5;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } tg_state_e;
endpackage

// File: rtl/tg_trip_detect.sv
// Module: tg_trip_detect
// Compares both signed readings against their limits and picks the cause.
// The board sensor wins when both are hot. The output is qualified by arm.
// Assumes: the readings are already synchronous to clk.
module tg_trip_detect
    import tg_pkg::*;
#(
    parameter int TEMP_W       = 12,
    parameter int LOCAL_LIMIT  = 85,
    parameter int REMOTE_LIMIT = 100
) (
    input  logic                     arm,
    input  logic signed [TEMP_W-1:0] local_temp,
    input  logic signed [TEMP_W-1:0] remote_temp,
    output logic                     fire,
    output logic [CAUSE_W-1:0]       cause
);
    localparam logic signed [TEMP_W-1:0] LOC_LIM = $signed(TEMP_W'(LOCAL_LIMIT));
    localparam logic signed [TEMP_W-1:0] REM_LIM = $signed(TEMP_W'(REMOTE_LIMIT));

    logic loc_hot;
    logic rem_hot;

    // Strict signed comparison against each limit.
    always_comb begin
        loc_hot = (local_temp  > LOC_LIM);
        rem_hot = (remote_temp > REM_LIM);
    end

    // Fire qualification and cause priority (board sensor first).
    always_comb begin
        fire  = arm && (loc_hot || rem_hot);
        cause = loc_hot ? CAUSE_LOCAL : CAUSE_REMOTE;
    end
endmodule

// File: rtl/tg_len_ctrl.sv
// Module: tg_len_ctrl
// Holds the cooldown length. Grows it by a step, with a clamp, when power
// is restored. Returns it to the minimum once the run-time stability window
// completes without a trip.
// Assumes: restore and running are never high in the same cycle.
module tg_len_ctrl #(
    parameter int CNT_W       = 9,
    parameter int CD_MIN      = 5,
    parameter int CD_STEP     = 30,
    parameter int CD_MAX      = 300,
    parameter int STABLE_SECS = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             restore,
    output logic [CNT_W-1:0] len
);
    localparam int WIN_W = $clog2(STABLE_SECS + 1);
    localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(STABLE_SECS);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(STABLE_SECS - 1);

    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] grown;
    logic             expire;

    // Next length after a cooldown, clamped to the ceiling.
    always_comb begin
        sum   = {1'b0, len} + (CNT_W+1)'(CD_STEP);
        grown = (sum > (CNT_W+1)'(CD_MAX)) ? CNT_W'(CD_MAX) : sum[CNT_W-1:0];
    end

    // Window completes on the tick that brings the count to its end.
    always_comb expire = running && tick && (win_cnt == WIN_LAST);

    // Stability window counter: cleared on restore, saturates at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || restore)
            win_cnt <= '0;
        else if (running && tick && win_cnt != WIN_END)
            win_cnt <= win_cnt + 1'b1;
    end

    // Length register: grow on restore, fall back to minimum on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len <= CNT_W'(CD_MIN);
        else if (restore)
            len <= grown;
        else if (expire)
            len <= CNT_W'(CD_MIN);
    end

    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (len >= CNT_W'(CD_MIN)) && (len <= CNT_W'(CD_MAX))); // R7
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(len) |-> (len == CNT_W'(CD_MIN) || len == CNT_W'(CD_MAX) ||
                           int'(len) == int'($past(len)) + CD_STEP)); // R7
    AST_WIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restore) |-> (win_cnt == '0)); // R8
endmodule

// File: rtl/tg_off_timer.sv
// Module: tg_off_timer
// Counts down the cooldown in 1 Hz ticks and flags the tick that ends it.
// Assumes: the loaded value is at least 1.
module tg_off_timer #(
    parameter int CNT_W  = 9,
    parameter int CD_MAX = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] remain;

    // Final tick of the cooldown.
    always_comb done = active && tick && (remain == CNT_W'(1));

    // Remaining-seconds counter: load on trip, decrement on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (active && tick && remain != '0)
            remain <= remain - 1'b1;
    end

    AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= CNT_W'(CD_MAX)); // R6
    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(load) && $past(active)) |-> (remain != '0)); // R6
endmodule

// File: rtl/thermal_guard.sv
// Module: thermal_guard (top)
// Removes primary power when a temperature limit is exceeded, holds it off
// for an escalating cooldown, then restores it. Emits a trip pulse with a
// cause code for the reset-cause logic.
// Assumes: tick_1hz is a single-cycle strobe; readings are synchronous.
module thermal_guard
    import tg_pkg::*;
#(
    parameter int TEMP_W       = 12,
    parameter int LOCAL_LIMIT  = 85,
    parameter int REMOTE_LIMIT = 100,
    parameter int CD_MIN       = 5,
    parameter int CD_STEP      = 30,
    parameter int CD_MAX       = 300,
    parameter int STABLE_SECS  = 300,
    parameter int CNT_W        = $clog2(CD_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_1hz,
    input  logic                     prot_en,
    input  logic signed [TEMP_W-1:0] local_temp,
    input  logic signed [TEMP_W-1:0] remote_temp,
    output logic                     pwr_en,
    output logic                     trip_pulse,
    output logic [3:0]               trip_cause,
    output logic [CNT_W-1:0]         cooldown_secs
);
    tg_state_e        state;
    logic             arm;
    logic             fire;
    logic [CAUSE_W-1:0] fire_cause;
    logic             done;
    logic [CNT_W-1:0] len;

    // Detection is armed only while powered and enabled.
    always_comb arm = prot_en && (state == ST_RUN);

    tg_trip_detect #(
        .TEMP_W      (TEMP_W),
        .LOCAL_LIMIT (LOCAL_LIMIT),
        .REMOTE_LIMIT(REMOTE_LIMIT)
    ) u_detect (
        .arm        (arm),
        .local_temp (local_temp),
        .remote_temp(remote_temp),
        .fire       (fire),
        .cause      (fire_cause)
    );

    tg_off_timer #(
        .CNT_W (CNT_W),
        .CD_MAX(CD_MAX)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .active  (state == ST_OFF),
        .load    (fire),
        .load_val(len),
        .done    (done)
    );

    tg_len_ctrl #(
        .CNT_W      (CNT_W),
        .CD_MIN     (CD_MIN),
        .CD_STEP    (CD_STEP),
        .CD_MAX     (CD_MAX),
        .STABLE_SECS(STABLE_SECS)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .running(state == ST_RUN),
        .restore(done),
        .len    (len)
    );

    // Power state machine with the registered trip pulse and cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            trip_pulse <= 1'b0;
            trip_cause <= '0;
        end else begin
            trip_pulse <= 1'b0;
            case (state)
                ST_RUN: if (fire) begin
                    state      <= ST_OFF;
                    trip_pulse <= 1'b1;
                    trip_cause <= fire_cause;
                end
                ST_OFF: if (done) state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Outputs taken straight from state.
    always_comb begin
        pwr_en        = (state == ST_RUN);
        cooldown_secs = len;
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |=> !trip_pulse); // R10
    AST_PULSE_DROPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |-> !pwr_en); // R6
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |-> (trip_cause == CAUSE_LOCAL || trip_cause == CAUSE_REMOTE)); // R4
    AST_TRIP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |-> $past(prot_en)); // R5
    AST_OFF_IGNORES_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !$past(pwr_en)) |-> !trip_pulse); // R9
endmodule

// File: tb/thermal_guard_bench.sv
`timescale 1ns/1ps
module thermal_guard_bench;
    localparam int TEMP_W = 12;
    localparam int CNT_W  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0;
    logic prot_en = 1'b0;
    logic signed [TEMP_W-1:0] local_temp  = 12'sd25;
    logic signed [TEMP_W-1:0] remote_temp = 12'sd40;
    logic pwr_en;
    logic trip_pulse;
    logic [3:0] trip_cause;
    logic [CNT_W-1:0] cooldown_secs;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    thermal_guard u_thermal_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1hz     (tick_1hz),
        .prot_en      (prot_en),
        .local_temp   (local_temp),
        .remote_temp  (remote_temp),
        .pwr_en       (pwr_en),
        .trip_pulse   (trip_pulse),
        .trip_cause   (trip_cause),
        .cooldown_secs(cooldown_secs)
    );

    // Pulse counter sampled between edges.
    always @(negedge clk) if (rst_n && trip_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1; step();
            tick_1hz = 1'b0; step();
        end
    endtask

    task automatic cool();
        local_temp  = 12'sd25;
        remote_temp = 12'sd40;
    endtask

    task automatic t_reset();
        chk("R1 pwr_en after reset", int'(pwr_en), 1);
        chk("R1 pulse after reset", int'(trip_pulse), 0);
        chk("R1 cooldown after reset", int'(cooldown_secs), 5);
    endtask

    task automatic t_limits();
        int base = pulses;
        prot_en = 1'b1;
        local_temp = 12'sd85; step(); step();
        chk("R2 board at 85 no trip", pulses - base, 0);
        cool(); remote_temp = 12'sd100; step(); step();
        chk("R3 remote at 100 no trip", pulses - base, 0);
        local_temp = -12'sd40; remote_temp = -12'sd55; step(); step();
        chk("R11 negative readings no trip", pulses - base, 0);
        chk("R11 power stays on", int'(pwr_en), 1);
        cool();
    endtask

    task automatic t_disabled();
        int base = pulses;
        prot_en = 1'b0;
        local_temp = 12'sd120; remote_temp = 12'sd120;
        repeat (6) step();
        chk("R5 no trip while disabled", pulses - base, 0);
        chk("R5 power on while disabled", int'(pwr_en), 1);
        cool(); step();
        prot_en = 1'b1;
    endtask

    // One trip and its full cooldown; optionally holds sensors hot while off.
    task automatic run_trip(input bit hot_loc, input bit hot_rem, input int exp_cause,
                            input int period, input bit hold_hot);
        int base = pulses;
        int next_len = (period + 30 > 300) ? 300 : period + 30;
        chk("R6 length before trip", int'(cooldown_secs), period);
        if (hot_loc) local_temp = 12'sd86;
        if (hot_rem) remote_temp = 12'sd101;
        step();
        chk(hot_loc ? "R2 board trip pulse" : "R3 remote trip pulse", int'(trip_pulse), 1);
        chk("R4 cause code", int'(trip_cause), exp_cause);
        chk("R6 power off with pulse", int'(pwr_en), 0);
        if (!hold_hot) cool();
        else begin local_temp = 12'sd120; remote_temp = 12'sd130; end
        step();
        chk("R10 pulse one cycle", int'(trip_pulse), 0);
        do_tick(period - 1);
        chk("R6 still off one tick early", int'(pwr_en), 0);
        cool();
        do_tick(1);
        chk("R6 power on after cooldown", int'(pwr_en), 1);
        chk("R7 length grown", int'(cooldown_secs), next_len);
        if (hold_hot) chk("R9 no pulses while off", pulses - base, 1);
    endtask

    task automatic t_escalate();
        for (int p = 125; p <= 275; p += 30) run_trip(1'b1, 1'b0, 4, p, 1'b0);
        chk("R7 reached ceiling", int'(cooldown_secs), 300);
        run_trip(1'b0, 1'b1, 5, 300, 1'b0);
        chk("R7 stays at ceiling", int'(cooldown_secs), 300);
    endtask

    task automatic t_stable();
        do_tick(299);
        chk("R8 length kept at 299 ticks", int'(cooldown_secs), 300);
        do_tick(1);
        chk("R8 length back to minimum at 300 ticks", int'(cooldown_secs), 5);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_limits();
        t_disabled();
        run_trip(1'b1, 1'b0, 4, 5, 1'b0);
        run_trip(1'b0, 1'b1, 5, 35, 1'b0);
        run_trip(1'b1, 1'b1, 4, 65, 1'b0);
        run_trip(1'b1, 1'b1, 4, 95, 1'b1);
        t_escalate();
        t_stable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R6 watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule